// File: doc/BRIEF.md
# Banked Register Mode Switcher

This block keeps the per-mode copies of the registers that a small processor core swaps when it changes operating mode. It holds the live stack pointer, link register and saved status word, plus five upper general registers (r8 to r12). Behind these it keeps one stored bank of stack pointer, link register and saved status per privilege bank. It also keeps two stored sets of the five upper registers: one used outside fast-interrupt mode and one private to fast-interrupt mode.

The core drives a requested mode together with a one-cycle strobe. On a real change, the block writes the live copies into the bank of the mode being left. It then loads the live copies from the bank of the mode being entered, and the new mode and the swapped registers appear together in the next cycle.

Between switches, the core updates the live copies through simple write ports. An encoding that names no mode leaves everything untouched and raises a sticky error flag. Reset puts the block into supervisor mode with every register cleared.

Top module: `banked_mode_switcher`

## Requirements
- R1: Modes use 5-bit codes: user 0x10, fast-interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B, system 0x1F. User and system share one bank; each of the other five modes has a bank of its own, so six banks exist.
- R2: A strobe that requests the mode already current changes no output in the following cycle.
- R3: On a real switch, the live stack pointer, link register and saved status are stored into the departing mode's bank. The live outputs show the arriving mode's stored values in the cycle after the strobe. Between user and system they keep their values.
- R4: After a strobe with a valid code, `cur_mode` equals the requested code in the next cycle.
- R5: Entering fast-interrupt mode from any other mode stores the live r8 to r12 as the user copy and loads the fast-interrupt private set into them.
- R6: Leaving fast-interrupt mode stores the live r8 to r12 into the private set and restores the user copy into them.
- R7: A switch in which neither the old nor the new mode is fast-interrupt leaves r8 to r12 unchanged.
- R8: A strobe with any code not listed in R1 sets `mode_err`, which stays set until reset, and changes neither the mode nor any register.
- R9: With no strobe, an asserted write enable updates its live register in the next cycle. `wr_hi_sel` 0 to 4 selects r8 to r12, and values 5 to 7 write nothing. All writes are ignored in a cycle where `switch_req` is high.
- R10: Synchronous reset sets the mode to supervisor, clears `mode_err`, and clears all live and stored registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| switch_req | input | 1 | One-cycle mode change strobe |
| req_mode | input | 5 | Requested mode code |
| wr_sp_en | input | 1 | Live stack pointer write enable |
| wr_sp_data | input | DATA_W | Live stack pointer write value |
| wr_lr_en | input | 1 | Live link register write enable |
| wr_lr_data | input | DATA_W | Live link register write value |
| wr_spsr_en | input | 1 | Live saved status write enable |
| wr_spsr_data | input | DATA_W | Live saved status write value |
| wr_hi_en | input | 1 | Upper register write enable |
| wr_hi_sel | input | 3 | Upper register select, 0 = r8 |
| wr_hi_data | input | DATA_W | Upper register write value |
| cur_mode | output | 5 | Current mode code |
| mode_err | output | 1 | Sticky bad-mode flag |
| live_sp | output | DATA_W | Live stack pointer |
| live_lr | output | DATA_W | Live link register |
| live_spsr | output | DATA_W | Live saved status |
| live_hi | output | NUM_HI*DATA_W | Live r8..r12, r8 in the low word |

## Verification
The bench walks through all six banks with distinct values and returns to each one. A design that used the wrong bank index, or loaded before saving, would show another mode's stack pointer. It switches between user and system, where a design that treated them as separate banks would lose the live values. It also goes into and out of fast-interrupt mode repeatedly, where a swapped save and restore direction would return the private set to user code. Last, it sends a bad code, a same-mode request, and writes that coincide with a strobe. A design that acted on any of these would change a register that must hold.

// File: rtl/bank_switch_pkg.sv
package bank_switch_pkg;

    localparam int MODE_W     = 5;
    localparam int NUM_BANKS  = 6;
    localparam int BANK_IDX_W = $clog2(NUM_BANKS);

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'h10,
        MODE_FIQ = 5'h11,
        MODE_IRQ = 5'h12,
        MODE_SVC = 5'h13,
        MODE_ABT = 5'h17,
        MODE_UND = 5'h1B,
        MODE_SYS = 5'h1F
    } cpu_mode_e;

    typedef enum logic [1:0] {
        HI_KEEP      = 2'd0,
        HI_ENTER_FIQ = 2'd1,
        HI_LEAVE_FIQ = 2'd2
    } hi_action_e;

    typedef struct packed {
        logic                  do_switch;
        logic                  bad_mode;
        logic [BANK_IDX_W-1:0] old_bank;
        logic [BANK_IDX_W-1:0] new_bank;
        logic                  same_bank;
        hi_action_e            hi_act;
    } switch_plan_t;

    function automatic logic mode_is_valid(input logic [MODE_W-1:0] m);
        case (m)
            MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
            MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

    // user and system share bank 0
    function automatic logic [BANK_IDX_W-1:0] bank_of(input logic [MODE_W-1:0] m);
        case (m)
            MODE_SVC: return BANK_IDX_W'(1);
            MODE_ABT: return BANK_IDX_W'(2);
            MODE_UND: return BANK_IDX_W'(3);
            MODE_IRQ: return BANK_IDX_W'(4);
            MODE_FIQ: return BANK_IDX_W'(5);
            default:  return BANK_IDX_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/mode_ctrl.sv
module mode_ctrl
    import bank_switch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              switch_req,
    input  logic [MODE_W-1:0] req_mode,
    output logic [MODE_W-1:0] cur_mode,
    output logic              mode_err,
    output switch_plan_t      plan
);

    logic req_valid;
    logic req_differs;

    always_comb begin
        req_valid   = mode_is_valid(req_mode);
        req_differs = (req_mode != cur_mode);

        plan           = '0;
        plan.hi_act    = HI_KEEP;
        plan.bad_mode  = switch_req && !req_valid;
        plan.do_switch = switch_req && req_valid && req_differs;
        plan.old_bank  = bank_of(cur_mode);
        plan.new_bank  = bank_of(req_mode);
        plan.same_bank = (plan.old_bank == plan.new_bank);
        if (plan.do_switch) begin
            if (cur_mode == MODE_FIQ)
                plan.hi_act = HI_LEAVE_FIQ;
            else if (req_mode == MODE_FIQ)
                plan.hi_act = HI_ENTER_FIQ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_mode <= MODE_SVC;
            mode_err <= 1'b0;
        end else begin
            if (plan.do_switch)
                cur_mode <= req_mode;
            if (plan.bad_mode)
                mode_err <= 1'b1;
        end
    end

endmodule

// File: rtl/bank_store.sv
module bank_store
    import bank_switch_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BANKS  = NUM_BANKS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  save_en,
    input  logic [BANK_IDX_W-1:0] save_idx,
    input  logic [DATA_W-1:0]     save_sp,
    input  logic [DATA_W-1:0]     save_lr,
    input  logic [DATA_W-1:0]     save_spsr,
    input  logic [BANK_IDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0]     rd_sp,
    output logic [DATA_W-1:0]     rd_lr,
    output logic [DATA_W-1:0]     rd_spsr
);

    logic [DATA_W-1:0] sp_q   [BANKS];
    logic [DATA_W-1:0] lr_q   [BANKS];
    logic [DATA_W-1:0] spsr_q [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                sp_q[b]   <= '0;
                lr_q[b]   <= '0;
                spsr_q[b] <= '0;
            end else if (save_en && (save_idx == BANK_IDX_W'(b))) begin
                sp_q[b]   <= save_sp;
                lr_q[b]   <= save_lr;
                spsr_q[b] <= save_spsr;
            end
        end
    end

    always_comb begin
        rd_sp   = '0;
        rd_lr   = '0;
        rd_spsr = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (rd_idx == BANK_IDX_W'(b)) begin
                rd_sp   = sp_q[b];
                rd_lr   = lr_q[b];
                rd_spsr = spsr_q[b];
            end
        end
    end

endmodule

// File: rtl/hi_reg_store.sv
module hi_reg_store
    import bank_switch_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_HI = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  hi_action_e               act,
    input  logic [NUM_HI*DATA_W-1:0] live_in,
    output logic [NUM_HI*DATA_W-1:0] restore_out
);

    logic [NUM_HI*DATA_W-1:0] usr_set_q;
    logic [NUM_HI*DATA_W-1:0] fiq_set_q;

    for (genvar i = 0; i < NUM_HI; i++) begin : g_word
        localparam int LO = i * DATA_W;
        always_ff @(posedge clk) begin
            if (rst) begin
                usr_set_q[LO +: DATA_W] <= '0;
                fiq_set_q[LO +: DATA_W] <= '0;
            end else begin
                case (act)
                    HI_ENTER_FIQ: usr_set_q[LO +: DATA_W] <= live_in[LO +: DATA_W];
                    HI_LEAVE_FIQ: fiq_set_q[LO +: DATA_W] <= live_in[LO +: DATA_W];
                    default: ;
                endcase
            end
        end
    end

    assign restore_out = (act == HI_ENTER_FIQ) ? fiq_set_q : usr_set_q;

endmodule

// File: rtl/banked_mode_switcher.sv
module banked_mode_switcher
    import bank_switch_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_HI = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     switch_req,
    input  logic [4:0]               req_mode,
    input  logic                     wr_sp_en,
    input  logic [DATA_W-1:0]        wr_sp_data,
    input  logic                     wr_lr_en,
    input  logic [DATA_W-1:0]        wr_lr_data,
    input  logic                     wr_spsr_en,
    input  logic [DATA_W-1:0]        wr_spsr_data,
    input  logic                     wr_hi_en,
    input  logic [2:0]               wr_hi_sel,
    input  logic [DATA_W-1:0]        wr_hi_data,
    output logic [4:0]               cur_mode,
    output logic                     mode_err,
    output logic [DATA_W-1:0]        live_sp,
    output logic [DATA_W-1:0]        live_lr,
    output logic [DATA_W-1:0]        live_spsr,
    output logic [NUM_HI*DATA_W-1:0] live_hi
);

    localparam int HI_W = NUM_HI * DATA_W;

    switch_plan_t             plan;
    logic [DATA_W-1:0]        bank_sp;
    logic [DATA_W-1:0]        bank_lr;
    logic [DATA_W-1:0]        bank_spsr;
    logic [HI_W-1:0]          hi_restore;
    logic                     writes_ok;

    mode_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .switch_req (switch_req),
        .req_mode   (req_mode),
        .cur_mode   (cur_mode),
        .mode_err   (mode_err),
        .plan       (plan)
    );

    bank_store #(.DATA_W(DATA_W), .BANKS(NUM_BANKS)) u_banks (
        .clk       (clk),
        .rst       (rst),
        .save_en   (plan.do_switch),
        .save_idx  (plan.old_bank),
        .save_sp   (live_sp),
        .save_lr   (live_lr),
        .save_spsr (live_spsr),
        .rd_idx    (plan.new_bank),
        .rd_sp     (bank_sp),
        .rd_lr     (bank_lr),
        .rd_spsr   (bank_spsr)
    );

    hi_reg_store #(.DATA_W(DATA_W), .NUM_HI(NUM_HI)) u_hi (
        .clk         (clk),
        .rst         (rst),
        .act         (plan.hi_act),
        .live_in     (live_hi),
        .restore_out (hi_restore)
    );

    assign writes_ok = !switch_req;

    // stack pointer, link and saved status live copies
    always_ff @(posedge clk) begin
        if (rst) begin
            live_sp   <= '0;
            live_lr   <= '0;
            live_spsr <= '0;
        end else if (plan.do_switch) begin
            // a shared bank was just written with the live value: keep it
            if (!plan.same_bank) begin
                live_sp   <= bank_sp;
                live_lr   <= bank_lr;
                live_spsr <= bank_spsr;
            end
        end else if (writes_ok) begin
            if (wr_sp_en)   live_sp   <= wr_sp_data;
            if (wr_lr_en)   live_lr   <= wr_lr_data;
            if (wr_spsr_en) live_spsr <= wr_spsr_data;
        end
    end

    // r8..r12 live copies
    for (genvar i = 0; i < NUM_HI; i++) begin : g_live_hi
        localparam int LO = i * DATA_W;
        always_ff @(posedge clk) begin
            if (rst) begin
                live_hi[LO +: DATA_W] <= '0;
            end else if (plan.hi_act != HI_KEEP) begin
                live_hi[LO +: DATA_W] <= hi_restore[LO +: DATA_W];
            end else if (writes_ok && wr_hi_en && (wr_hi_sel == 3'(i))) begin
                live_hi[LO +: DATA_W] <= wr_hi_data;
            end
        end
    end

endmodule

// File: rtl/bank_switch_checker.sv
module bank_switch_checker
    import bank_switch_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_HI = 5
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     switch_req,
    input logic [4:0]               req_mode,
    input logic [4:0]               cur_mode,
    input logic                     mode_err,
    input logic [DATA_W-1:0]        live_sp,
    input logic [DATA_W-1:0]        live_lr,
    input logic [DATA_W-1:0]        live_spsr,
    input logic [NUM_HI*DATA_W-1:0] live_hi
);

    assert_same_mode_hold_R2: assert property (@(posedge clk) disable iff (rst)
        switch_req && (req_mode == cur_mode) |=>
            $stable(live_sp) && $stable(live_lr) && $stable(live_spsr) &&
            $stable(live_hi) && $stable(cur_mode));

    assert_mode_follows_R4: assert property (@(posedge clk) disable iff (rst)
        switch_req && mode_is_valid(req_mode) |=> cur_mode == $past(req_mode));

    assert_hi_untouched_R7: assert property (@(posedge clk) disable iff (rst)
        switch_req && mode_is_valid(req_mode) && (req_mode != MODE_FIQ) &&
        (cur_mode != MODE_FIQ) |=> $stable(live_hi));

    assert_bad_code_R8: assert property (@(posedge clk) disable iff (rst)
        switch_req && !mode_is_valid(req_mode) |=>
            mode_err && $stable(cur_mode) && $stable(live_sp) &&
            $stable(live_lr) && $stable(live_spsr) && $stable(live_hi));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        mode_err |=> mode_err);

    assert_mode_legal_R1: assert property (@(posedge clk) disable iff (rst)
        mode_is_valid(cur_mode));

    assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cur_mode == MODE_SVC) && !mode_err &&
            (live_sp == '0) && (live_hi == '0));

endmodule

bind banked_mode_switcher bank_switch_checker #(.DATA_W(DATA_W), .NUM_HI(NUM_HI)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .switch_req (switch_req),
    .req_mode   (req_mode),
    .cur_mode   (cur_mode),
    .mode_err   (mode_err),
    .live_sp    (live_sp),
    .live_lr    (live_lr),
    .live_spsr  (live_spsr),
    .live_hi    (live_hi)
);

// File: tb/banked_mode_switcher_tb.sv
module banked_mode_switcher_tb_top;

    localparam int DW = 32;
    localparam int NH = 5;

    logic clk = 1'b0;
    logic rst;
    logic switch_req;
    logic [4:0] req_mode;
    logic wr_sp_en, wr_lr_en, wr_spsr_en, wr_hi_en;
    logic [DW-1:0] wr_sp_data, wr_lr_data, wr_spsr_data, wr_hi_data;
    logic [2:0] wr_hi_sel;
    logic [4:0] cur_mode;
    logic mode_err;
    logic [DW-1:0] live_sp, live_lr, live_spsr;
    logic [NH*DW-1:0] live_hi;

    always #4 clk = ~clk;

    banked_mode_switcher #(.DATA_W(DW), .NUM_HI(NH)) dut_i (
        .clk(clk), .rst(rst), .switch_req(switch_req), .req_mode(req_mode),
        .wr_sp_en(wr_sp_en), .wr_sp_data(wr_sp_data),
        .wr_lr_en(wr_lr_en), .wr_lr_data(wr_lr_data),
        .wr_spsr_en(wr_spsr_en), .wr_spsr_data(wr_spsr_data),
        .wr_hi_en(wr_hi_en), .wr_hi_sel(wr_hi_sel), .wr_hi_data(wr_hi_data),
        .cur_mode(cur_mode), .mode_err(mode_err),
        .live_sp(live_sp), .live_lr(live_lr), .live_spsr(live_spsr),
        .live_hi(live_hi)
    );

    // mode codes per R1
    localparam logic [4:0] USR = 5'h10, FIQ = 5'h11, IRQ = 5'h12, SVC = 5'h13,
                           ABT = 5'h17, UND = 5'h1B, SYS = 5'h1F;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // reference model state
    logic [4:0]    m_mode;
    logic          m_err;
    logic [DW-1:0] m_sp, m_lr, m_spsr;
    logic [DW-1:0] m_hi [NH];
    logic [DW-1:0] m_bsp [6];
    logic [DW-1:0] m_blr [6];
    logic [DW-1:0] m_bspsr [6];
    logic [DW-1:0] m_usr_hi [NH];
    logic [DW-1:0] m_fiq_hi [NH];

    function automatic bit legal(input logic [4:0] m);
        return (m == USR) || (m == FIQ) || (m == IRQ) || (m == SVC) ||
               (m == ABT) || (m == UND) || (m == SYS);
    endfunction

    function automatic int bank(input logic [4:0] m);
        case (m)
            SVC: return 1; ABT: return 2; UND: return 3;
            IRQ: return 4; FIQ: return 5; default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "mode", DW'(cur_mode), DW'(m_mode));
        chk(req, "err", DW'(mode_err), DW'(m_err));
        chk(req, "sp", live_sp, m_sp);
        chk(req, "lr", live_lr, m_lr);
        chk(req, "spsr", live_spsr, m_spsr);
        for (int i = 0; i < NH; i++)
            chk(req, $sformatf("hi%0d", i), live_hi[i*DW +: DW], m_hi[i]);
    endtask

    task automatic idle_inputs();
        switch_req = 0; req_mode = SVC;
        wr_sp_en = 0; wr_lr_en = 0; wr_spsr_en = 0; wr_hi_en = 0;
        wr_sp_data = '0; wr_lr_data = '0; wr_spsr_data = '0;
        wr_hi_data = '0; wr_hi_sel = '0;
    endtask

    // inputs applied after a falling edge, one rising edge, then sampled
    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic write_live(input logic [DW-1:0] base);
        wr_sp_en = 1; wr_sp_data = base + 1;
        wr_lr_en = 1; wr_lr_data = base + 2;
        wr_spsr_en = 1; wr_spsr_data = base + 3;
        step();
        m_sp = base + 1; m_lr = base + 2; m_spsr = base + 3;
        for (int i = 0; i < NH; i++) begin
            wr_hi_en = 1; wr_hi_sel = 3'(i); wr_hi_data = base + 32'h10 + i;
            step();
            m_hi[i] = base + 32'h10 + i;
        end
    endtask

    task automatic switch_to(input logic [4:0] m);
        int ob, nb;
        switch_req = 1; req_mode = m;
        step();
        if (!legal(m)) begin
            m_err = 1;
        end else if (m != m_mode) begin
            ob = bank(m_mode); nb = bank(m);
            m_bsp[ob] = m_sp; m_blr[ob] = m_lr; m_bspsr[ob] = m_spsr;
            m_sp = m_bsp[nb]; m_lr = m_blr[nb]; m_spsr = m_bspsr[nb];
            if (m_mode == FIQ) begin
                for (int i = 0; i < NH; i++) begin
                    m_fiq_hi[i] = m_hi[i]; m_hi[i] = m_usr_hi[i];
                end
            end else if (m == FIQ) begin
                for (int i = 0; i < NH; i++) begin
                    m_usr_hi[i] = m_hi[i]; m_hi[i] = m_fiq_hi[i];
                end
            end
            m_mode = m;
        end
    endtask

    task automatic model_reset();
        m_mode = SVC; m_err = 0; m_sp = '0; m_lr = '0; m_spsr = '0;
        for (int i = 0; i < NH; i++) begin
            m_hi[i] = '0; m_usr_hi[i] = '0; m_fiq_hi[i] = '0;
        end
        for (int b = 0; b < 6; b++) begin
            m_bsp[b] = '0; m_blr[b] = '0; m_bspsr[b] = '0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs(); rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    task automatic t_reset_R10();
        do_reset();
        check_all("R10");
    endtask

    task automatic t_writes_R9();
        write_live(32'hA000_0000);
        check_all("R9");
        wr_hi_en = 1; wr_hi_sel = 3'd5; wr_hi_data = 32'hDEAD_0005;
        step();
        check_all("R9");  // select 5 writes nothing
        wr_sp_en = 1; wr_sp_data = 32'hDEAD_BEEF;
        wr_hi_en = 1; wr_hi_sel = 3'd0; wr_hi_data = 32'hDEAD_0000;
        switch_to(ABT);   // writes dropped in a strobe cycle
        check_all("R9");
        switch_to(SVC);
        check_all("R9");
    endtask

    task automatic t_same_mode_R2();
        switch_to(SVC);
        check_all("R2");
    endtask

    task automatic t_all_banks_R3();
        logic [4:0] seq [6];
        seq[0] = IRQ; seq[1] = ABT; seq[2] = UND; seq[3] = USR;
        seq[4] = FIQ; seq[5] = SVC;
        for (int k = 0; k < 6; k++) begin
            switch_to(seq[k]);
            check_all("R3");
            chk("R4", "mode", DW'(cur_mode), DW'(seq[k]));
            write_live(32'h1000_0000 * (k + 1));
        end
        for (int k = 0; k < 6; k++) begin
            switch_to(seq[k]);
            check_all("R3");
        end
    endtask

    task automatic t_usr_sys_R1();
        switch_to(USR);
        write_live(32'h5500_0000);
        switch_to(SYS);
        chk("R1", "sp shared", live_sp, 32'h5500_0001);
        check_all("R1");
        switch_to(USR);
        check_all("R1");
    endtask

    task automatic t_fiq_R5_R6();
        switch_to(IRQ);
        write_live(32'h7700_0000);
        switch_to(FIQ);
        check_all("R5");
        write_live(32'h8800_0000);
        switch_to(UND);
        chk("R6", "r8 restored", live_hi[DW-1:0], 32'h7700_0010);
        check_all("R6");
        switch_to(ABT);
        check_all("R7");
        switch_to(FIQ);
        chk("R5", "r8 private", live_hi[DW-1:0], 32'h8800_0010);
        check_all("R5");
        switch_to(SVC);
        check_all("R6");
    endtask

    task automatic t_bad_mode_R8();
        switch_to(5'h00);
        check_all("R8");
        switch_to(5'h15);
        check_all("R8");
        switch_to(IRQ);
        check_all("R8");  // flag stays set
        do_reset();
        check_all("R10");
    endtask

    initial begin
        rst = 1;
        idle_inputs();
        model_reset();
        t_reset_R10();
        t_writes_R9();
        t_same_mode_R2();
        t_all_banks_R3();
        t_usr_sys_R1();
        t_fiq_R5_R6();
        t_bad_mode_R8();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule